// File: doc/BRIEF.md
# DMA Interrupt Status and Mask Unit

This block gathers the error and event conditions raised by a DMA engine into a sticky status register. A per-bit enable register decides which of those conditions may pull the active-low interrupt request line. The status bits also drive two other outputs. One is a summary flag that tells the chip-level interrupt logic a DMA interrupt is pending. The other is a halt request that stops the script sequencer. Both outputs act whatever the enable bits hold, because every DMA condition counts as fatal.

Software reads and writes the enable register through a simple write strobe and read-data port. It reads the status register with a strobe that returns the current bits and clears them in the same cycle. The interrupt line is latched. Once pulled low it stays low until the status register is read, even if the enable bits are cleared in the meantime.

Top module: `dmairq_unit`

## Requirements
- R1: A one-cycle pulse on a defined event input sets the status bit at the same position on the next clock edge. The defined positions are bit 0 illegal opcode, bit 2 script interrupt opcode, bit 3 single-step, bit 4 abort, bit 5 bus error and bit 6 master parity error. Pulses on bits 1 and 7 are ignored, and those status bits always read 0.
- R2: An event sets its status bit whether or not the matching enable bit is set. A condition that is set but masked never pulls `irq_n` low.
- R3: When some status bit and its enable bit are both 1 in a cycle without a status read, `irq_n` is low from the next clock edge.
- R4: Once low, `irq_n` stays low until a status read. Clearing enable bits does not release it. It returns high on the edge that ends the read cycle.
- R5: `dma_pend` is high exactly while any status bit is 1, masked or not.
- R6: `halt_req` is high while any status bit is 1, masked or not. It drops after the read that clears the status.
- R7: A status read returns the current bits on `stat_rdata` and clears them at the next edge. An event pulsed in the read cycle is kept set.
- R8: A write to the enable register takes effect at the next edge and is read back on `mask_rdata`. Bits 1 and 7 always read 0, and all enable bits are 0 after reset.
- R9: A set, masked condition does not stop an enabled condition from pulling `irq_n` low.
- R10: Reset is asserted asynchronously by `rst_n` low. It clears the status and enable bits and sets `irq_n` high at once. Its release is synchronised to the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 8 | One-cycle event pulses, one per condition bit |
| mask_we | input | 1 | Enable register write strobe |
| mask_wdata | input | 8 | Enable register write data |
| mask_rdata | output | 8 | Enable register contents |
| stat_rd | input | 1 | Status read strobe (clears status) |
| stat_rdata | output | 8 | Current status bits |
| irq_n | output | 1 | Latched interrupt request, active low |
| dma_pend | output | 1 | Summary DMA interrupt pending flag |
| halt_req | output | 1 | Halt request to the script sequencer |

## Verification
Two things can land on the same edge: a clearing status read and a new event or interrupt condition. A directed case pulses an event in the read cycle while the line is latched low. It then expects the new bit to survive, the old bits to vanish and `irq_n` to rise for at least one cycle. Random stimulus issues reads, enable writes and event bursts independently, so these collisions recur many times. Every cycle is judged against a bench model that applies read-clear first and then ORs in the new events.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

  localparam int unsigned DW = 8;

  // Condition bit positions in status and enable registers
  localparam int unsigned POS_ILL_OP  = 0;
  localparam int unsigned POS_SCR_INT = 2;
  localparam int unsigned POS_STEP    = 3;
  localparam int unsigned POS_ABORT   = 4;
  localparam int unsigned POS_BUSERR  = 5;
  localparam int unsigned POS_PARERR  = 6;

  localparam logic [DW-1:0] SRC_MASK =
      (DW'(1) << POS_ILL_OP)  | (DW'(1) << POS_SCR_INT) |
      (DW'(1) << POS_STEP)    | (DW'(1) << POS_ABORT)   |
      (DW'(1) << POS_BUSERR)  | (DW'(1) << POS_PARERR);

  typedef logic [DW-1:0] dmairq_vec_t;

endpackage

// File: rtl/dmairq_rst_sync.sv
module dmairq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] sr_q;
  logic [N-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[N-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign rst_sync_n = sr_q[N-1];

endmodule

// File: rtl/dmairq_mask_reg.sv
module dmairq_mask_reg
  import dmairq_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] en_q
);

  localparam logic [W-1:0] VALID = W'(SRC_MASK);

  logic [W-1:0] en_d;
  logic         en_ld;

  always_comb begin
    en_ld = wr_en;
    en_d  = wr_data & VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ld) begin
      en_q <= en_d;
    end
  end

endmodule

// File: rtl/dmairq_status_reg.sv
module dmairq_status_reg
  import dmairq_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         rd_clr,
  output logic [W-1:0] st_q
);

  localparam logic [W-1:0] VALID = W'(SRC_MASK);

  logic [W-1:0] evt_ok;
  logic [W-1:0] st_d;
  logic         st_ld;

  // Read-clear applies first, new events are ORed in afterwards
  always_comb begin
    evt_ok = evt & VALID;
    st_ld  = rd_clr | (|evt_ok);
    st_d   = (rd_clr ? '0 : st_q) | evt_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (st_ld) begin
      st_q <= st_d;
    end
  end

endmodule

// File: rtl/dmairq_irq_latch.sv
module dmairq_irq_latch
  import dmairq_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] st,
  input  logic [W-1:0] en,
  input  logic         rd_clr,
  output logic         irq_q
);

  logic hit;
  logic irq_d;

  always_comb begin
    hit   = |(st & en);
    irq_d = rd_clr ? 1'b0 : (irq_q | hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/dmairq_unit.sv
module dmairq_unit
  import dmairq_pkg::*;
#(
  parameter int unsigned W           = DW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_evt,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  output logic [W-1:0] mask_rdata,
  input  logic         stat_rd,
  output logic [W-1:0] stat_rdata,
  output logic         irq_n,
  output logic         dma_pend,
  output logic         halt_req
);

  logic         rst_core_n;
  logic [W-1:0] st_q;
  logic [W-1:0] en_q;
  logic         irq_q;
  logic         any_st;

  dmairq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  dmairq_mask_reg #(.W(W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (mask_we),
    .wr_data (mask_wdata),
    .en_q    (en_q)
  );

  dmairq_status_reg #(.W(W)) u_stat (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .evt    (src_evt),
    .rd_clr (stat_rd),
    .st_q   (st_q)
  );

  dmairq_irq_latch #(.W(W)) u_irq (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .st     (st_q),
    .en     (en_q),
    .rd_clr (stat_rd),
    .irq_q  (irq_q)
  );

  always_comb begin
    any_st     = |st_q;
    mask_rdata = en_q;
    stat_rdata = st_q;
    irq_n      = ~irq_q;
    dma_pend   = any_st;
    halt_req   = any_st;
  end

endmodule

// File: rtl/dmairq_unit_chk.sv
module dmairq_unit_chk
  import dmairq_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] src_evt,
  input logic          mask_we,
  input logic [DW-1:0] mask_rdata,
  input logic          stat_rd,
  input logic [DW-1:0] stat_rdata,
  input logic          irq_n,
  input logic          dma_pend,
  input logic          halt_req
);

  assert_status_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_evt & SRC_MASK)) |=>
      ((stat_rdata & $past(src_evt & SRC_MASK)) == $past(src_evt & SRC_MASK)));

  assert_status_rsvd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata & ~SRC_MASK) == '0);

  assert_masked_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_evt & SRC_MASK & ~mask_rdata)) |=> dma_pend);

  assert_irq_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(stat_rdata & mask_rdata)) && !stat_rd) |=> !irq_n);

  assert_irq_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(|(stat_rdata & mask_rdata)));

  assert_irq_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !stat_rd) |=> !irq_n);

  assert_irq_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(stat_rd));

  assert_pend_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_pend) |-> $past(|(src_evt & SRC_MASK)));

  assert_halt_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_req) |-> $past(stat_rd));

  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> ((stat_rdata & ~$past(src_evt)) == '0));

  assert_mask_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_rdata & ~SRC_MASK) == '0);

  assert_mask_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_rdata));

endmodule

bind dmairq_unit dmairq_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .src_evt    (src_evt),
  .mask_we    (mask_we),
  .mask_rdata (mask_rdata),
  .stat_rd    (stat_rd),
  .stat_rdata (stat_rdata),
  .irq_n      (irq_n),
  .dma_pend   (dma_pend),
  .halt_req   (halt_req)
);

// File: tb/tb_dmairq_unit.sv
`timescale 1ns/1ps
module tb_dmairq_unit;
  import dmairq_pkg::*;

  logic       clk;
  logic       rst_n;
  logic [7:0] src_evt;
  logic       mask_we;
  logic [7:0] mask_wdata;
  logic [7:0] mask_rdata;
  logic       stat_rd;
  logic [7:0] stat_rdata;
  logic       irq_n;
  logic       dma_pend;
  logic       halt_req;

  int checks;
  int errors;
  bit done;

  logic [7:0] m_st;
  logic [7:0] m_en;
  logic       m_irq;

  localparam logic [7:0] VALID = 8'h7D;

  dmairq_unit dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_evt    (src_evt),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .mask_rdata (mask_rdata),
    .stat_rd    (stat_rd),
    .stat_rdata (stat_rdata),
    .irq_n      (irq_n),
    .dma_pend   (dma_pend),
    .halt_req   (halt_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(stat_rdata == m_st, "R1 R7 status", stat_rdata, m_st);
    chk(mask_rdata == m_en, "R8 enable", mask_rdata, m_en);
    chk(irq_n == ~m_irq, "R3 R4 irq_n", irq_n, ~m_irq);
    chk(dma_pend == (m_st != 0), "R5 pending", dma_pend, m_st != 0);
    chk(halt_req == (m_st != 0), "R6 halt", halt_req, m_st != 0);
  endtask

  function automatic logic next_irq(input logic irq, input logic [7:0] st,
                                    input logic [7:0] en, input logic rd);
    return rd ? 1'b0 : (irq | (|(st & en)));
  endfunction

  function automatic logic [7:0] next_st(input logic [7:0] st,
                                         input logic [7:0] e, input logic rd);
    return (rd ? 8'h00 : st) | (e & VALID);
  endfunction

  task automatic step(input logic [7:0] e, input logic we,
                      input logic [7:0] wd, input logic rd);
    logic       n_irq;
    logic [7:0] n_st;
    src_evt = e; mask_we = we; mask_wdata = wd; stat_rd = rd;
    @(posedge clk);
    n_irq = next_irq(m_irq, m_st, m_en, rd);
    n_st  = next_st(m_st, e, rd);
    if (we) m_en = wd & VALID;
    m_irq = n_irq;
    m_st  = n_st;
    @(negedge clk);
    src_evt = '0; mask_we = 1'b0; mask_wdata = '0; stat_rd = 1'b0;
    compare_all();
  endtask

  task automatic model_reset();
    m_st = '0; m_en = '0; m_irq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; src_evt = '0; mask_we = 1'b0; mask_wdata = '0; stat_rd = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(stat_rdata == 8'h00, "R10 reset status", stat_rdata, 0);
    chk(irq_n == 1'b1, "R10 reset irq_n", irq_n, 1);
    chk(mask_rdata == 8'h00, "R10 reset enable", mask_rdata, 0);
    chk(halt_req == 1'b0, "R10 reset halt", halt_req, 0);
    rst_n = 1'b1;
    repeat (4) step(8'h00, 1'b0, 8'h00, 1'b0);

    // R8 reserved enable bits read 0
    step(8'h00, 1'b1, 8'hFF, 1'b0);
    chk(mask_rdata == 8'h7D, "R8 enable reserved bits", mask_rdata, 8'h7D);
    step(8'h00, 1'b1, 8'h00, 1'b0);
    // R1 reserved event inputs ignored
    step(8'h82, 1'b0, 8'h00, 1'b0);
    chk(stat_rdata == 8'h00, "R1 reserved events ignored", stat_rdata, 0);
    chk(dma_pend == 1'b0, "R1 reserved events no pending", dma_pend, 0);
    // R2 masked bus error sets status, pending and halt, not irq
    step(8'h20, 1'b0, 8'h00, 1'b0);
    chk(stat_rdata == 8'h20, "R2 masked status set", stat_rdata, 8'h20);
    chk(dma_pend == 1'b1, "R5 masked pending", dma_pend, 1);
    chk(halt_req == 1'b1, "R6 masked halt", halt_req, 1);
    step(8'h00, 1'b0, 8'h00, 1'b0);
    chk(irq_n == 1'b1, "R2 masked no irq", irq_n, 1);
    // R9 enabled illegal-op gets through alongside masked bus error
    step(8'h00, 1'b1, 8'h01, 1'b0);
    step(8'h01, 1'b0, 8'h00, 1'b0);
    chk(irq_n == 1'b1, "R3 irq not yet", irq_n, 1);
    step(8'h00, 1'b0, 8'h00, 1'b0);
    chk(irq_n == 1'b0, "R9 unmasked irq asserted", irq_n, 0);
    // R4 clearing enable does not release irq
    step(8'h00, 1'b1, 8'h00, 1'b0);
    chk(irq_n == 1'b0, "R4 irq held after unmask", irq_n, 0);
    step(8'h00, 1'b0, 8'h00, 1'b0);
    chk(irq_n == 1'b0, "R4 irq still held", irq_n, 0);
    // R7 read with simultaneous single-step event
    chk(stat_rdata == 8'h21, "R7 read data", stat_rdata, 8'h21);
    step(8'h08, 1'b0, 8'h00, 1'b1);
    chk(stat_rdata == 8'h08, "R7 same-cycle event kept", stat_rdata, 8'h08);
    chk(irq_n == 1'b1, "R4 irq released by read", irq_n, 1);
    chk(halt_req == 1'b1, "R6 halt with kept event", halt_req, 1);
    step(8'h00, 1'b0, 8'h00, 1'b1);
    chk(halt_req == 1'b0, "R6 halt drops after read", halt_req, 0);
    chk(dma_pend == 1'b0, "R5 pending drops after read", dma_pend, 0);

    // Random phase
    for (int i = 0; i < 5000; i++) begin
      logic [7:0] e;
      logic we;
      logic rd;
      e  = (($urandom % 5) == 0) ? 8'($urandom) : 8'h00;
      we = (($urandom % 9) == 0);
      rd = (($urandom % 6) == 0);
      step(e, we, 8'($urandom), rd);
    end

    // R10 asynchronous reset mid-run
    step(8'h7D, 1'b1, 8'h7D, 1'b0);
    step(8'h00, 1'b0, 8'h00, 1'b0);
    rst_n = 1'b0;
    #1;
    model_reset();
    chk(irq_n == 1'b1, "R10 async reset irq_n", irq_n, 1);
    chk(stat_rdata == 8'h00, "R10 async reset status", stat_rdata, 0);
    chk(mask_rdata == 8'h00, "R10 async reset enable", mask_rdata, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(8'h00, 1'b0, 8'h00, 1'b0);
    for (int i = 0; i < 500; i++) begin
      step((($urandom % 4) == 0) ? 8'($urandom) : 8'h00,
           (($urandom % 7) == 0), 8'($urandom), (($urandom % 5) == 0));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule